// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a single-channel converter that takes its code over a three-wire serial port. A host frames each transfer with an active-low frame strobe. It shifts the word in, most significant bit first, and the word is captured on falling serial-clock edges. When the frame closes, a complete word is committed to an input register. The input register moves into the DAC holding register on a falling edge of an active-low load strobe. If the load strobe is already low when the frame closes, the holding register updates automatically. The low bits of the holding register form the converter code.

A readback enable shifts the holding register out on the serial output on rising clock edges. Outside readback, the serial output carries the word as it shifts, so that several devices can be chained. A falling edge on the active-low clear input parks the code at mid-scale, the zero-volt point of a bipolar range, without changing any register.

Every serial and control pin is sampled in the system clock domain through synchronisers, and edges are found there. The serial port is a plain clocked shift path. It has no valid/ready handshake and no back-pressure: the host owns the pace and must keep each clock level for several system clocks. The serial output is open-drain and is driven as a pull-low enable.

Top module: `dacsif_top`

## Requirements
- R1: After reset the code is mid-scale (only bit CODE_W-1 set; 0x2000 at defaults). The holding register holds that same mid-scale word and the input register holds zero, so the serial output pulls low outside readback.
- R2: While the frame strobe is low, each falling serial-clock edge shifts the data pin in, MSB first. At the frame strobe's rising edge, a frame of at least WORD_W edges commits its last WORD_W bits to the input register.
- R3: A frame with fewer than WORD_W falling edges is discarded. The input register and the holding register keep their values.
- R4: Serial-clock edges while the frame strobe is high shift nothing.
- R5: A falling edge of the load strobe copies the input register into the holding register. The code is the CODE_W low bits of the word, and the upper WORD_W-CODE_W bits have no effect on it.
- R6: If the load strobe is low when a complete frame ends, the holding register takes the new word directly.
- R7: With the load strobe high, a complete frame leaves the code unchanged.
- R8: While readback is enabled, the serial output first shows the MSB of the holding register. It then moves one bit towards the LSB on each rising serial-clock edge, for WORD_W bits.
- R9: Outside readback, the serial output shows the MSB of the shift path. During a frame it therefore emits the previously committed word, MSB first, with one bit before each falling edge.
- R10: A falling edge of the clear input forces the code to mid-scale until the next holding-register update, and the register contents stay unchanged. If a clear and an update fall on the same cycle, the clear wins.
- R11: The serial output is open-drain. `sdo_pull_o` = 1 drives the line low for a 0 bit, and 0 releases it for a 1 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdi_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low load strobe |
| rdbk_n_i | input | 1 | Active-low readback enable |
| clr_n_i | input | 1 | Active-low clear |
| sdo_pull_o | output | 1 | Open-drain pull-low enable for serial out |
| dac_code_o | output | CODE_W | Converter code |

## Verification
The bench builds the block with WORD_W = 8 and CODE_W = 6. This makes an exhaustive sweep practical: all 256 words are sent in automatic-update mode, and each is checked three ways. The bench checks the resulting code, reads the full word back, and checks the chained echo of the previous word. The small word also puts the discarded upper bits, mid-scale (0x20) and the long and short frame boundaries within a few frames. The sweep is followed by directed runs of load-strobe mode, clear and ignored clocks.

// File: rtl/dacsif_pkg.sv
package dacsif_pkg;
  // positions of the sampled pins inside the synchroniser vector
  localparam int unsigned PIN_SCK   = 0;
  localparam int unsigned PIN_FRAME = 1;
  localparam int unsigned PIN_LOAD  = 2;
  localparam int unsigned PIN_RDBK  = 3;
  localparam int unsigned PIN_CLR   = 4;
  localparam int unsigned PIN_SDI   = 5;
  localparam int unsigned PIN_NUM   = 6;
  // idle levels: strobes high, clock and data low
  localparam logic [PIN_NUM-1:0] PIN_IDLE = 6'b011110;
endpackage

// File: rtl/dacsif_sync.sv
module dacsif_sync #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stage [STAGES];
  logic [N-1:0] prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[s] <= IDLE;
        else        stage[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[s] <= IDLE;
        else        stage[s] <= stage[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= IDLE;
    else        prev <= stage[STAGES-1];

  assign lvl  = stage[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/dacsif_shift.sv
module dacsif_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sck_fall,
  input  logic              frame_lvl,
  input  logic              frame_fall,
  input  logic              frame_rise,
  output logic [WORD_W-1:0] work,
  output logic [WORD_W-1:0] in_reg,
  output logic              commit
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] cnt;
  logic             full;

  assign full   = (cnt == FULL);
  assign commit = frame_rise && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      work   <= '0;
      in_reg <= '0;
    end else if (frame_fall) begin
      cnt <= '0;
    end else if (frame_rise) begin
      if (full) in_reg <= work;
      else      work   <= in_reg;   // short frame: drop partial bits
    end else if (sck_fall && !frame_lvl) begin
      work <= {work[WORD_W-2:0], sdi};
      if (!full) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dacsif_hold.sv
module dacsif_hold #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] new_word,
  input  logic [WORD_W-1:0] in_reg,
  input  logic              load_lvl,
  input  logic              load_fall,
  input  logic              clr_fall,
  output logic [WORD_W-1:0] dac_word,
  output logic [CODE_W-1:0] dac_code
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [WORD_W-1:0] MID_WORD = WORD_W'(MID_CODE);

  logic parked;
  logic upd_auto, upd_load;

  assign upd_auto = commit && !load_lvl;
  assign upd_load = load_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_word <= MID_WORD;
      parked   <= 1'b0;
    end else begin
      if (upd_auto)      dac_word <= new_word;
      else if (upd_load) dac_word <= in_reg;
      if (clr_fall)                  parked <= 1'b1;
      else if (upd_auto || upd_load) parked <= 1'b0;
    end
  end

  assign dac_code = parked ? MID_CODE : dac_word[CODE_W-1:0];
endmodule

// File: rtl/dacsif_rdbk.sv
module dacsif_rdbk #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdbk_lvl,
  input  logic              rdbk_fall,
  input  logic              sck_rise,
  input  logic [WORD_W-1:0] dac_word,
  output logic              rb_act,
  output logic              rb_bit
);
  logic [WORD_W-1:0] rb_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rb_sh <= '0;
    else if (rdbk_fall)             rb_sh <= dac_word;
    else if (!rdbk_lvl && sck_rise) rb_sh <= {rb_sh[WORD_W-2:0], 1'b0};
  end

  assign rb_act = !rdbk_lvl;
  assign rb_bit = rb_sh[WORD_W-1];
endmodule

// File: rtl/dacsif_top.sv
module dacsif_top #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CODE_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              frame_n_i,
  input  logic              sdi_i,
  input  logic              load_n_i,
  input  logic              rdbk_n_i,
  input  logic              clr_n_i,
  output logic              sdo_pull_o,
  output logic [CODE_W-1:0] dac_code_o
);
  import dacsif_pkg::*;

  logic [PIN_NUM-1:0] pins, s_lvl, s_rise, s_fall;
  logic [WORD_W-1:0]  work, in_reg, dac_word;
  logic               commit, rb_act, rb_bit, out_bit;

  assign pins[PIN_SCK]   = sck_i;
  assign pins[PIN_FRAME] = frame_n_i;
  assign pins[PIN_LOAD]  = load_n_i;
  assign pins[PIN_RDBK]  = rdbk_n_i;
  assign pins[PIN_CLR]   = clr_n_i;
  assign pins[PIN_SDI]   = sdi_i;

  dacsif_sync #(.N(PIN_NUM), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  dacsif_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sdi(s_lvl[PIN_SDI]), .sck_fall(s_fall[PIN_SCK]),
    .frame_lvl(s_lvl[PIN_FRAME]), .frame_fall(s_fall[PIN_FRAME]),
    .frame_rise(s_rise[PIN_FRAME]),
    .work(work), .in_reg(in_reg), .commit(commit)
  );

  dacsif_hold #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .commit(commit), .new_word(work),
    .in_reg(in_reg), .load_lvl(s_lvl[PIN_LOAD]), .load_fall(s_fall[PIN_LOAD]),
    .clr_fall(s_fall[PIN_CLR]), .dac_word(dac_word), .dac_code(dac_code_o)
  );

  dacsif_rdbk #(.WORD_W(WORD_W)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .rdbk_lvl(s_lvl[PIN_RDBK]),
    .rdbk_fall(s_fall[PIN_RDBK]), .sck_rise(s_rise[PIN_SCK]),
    .dac_word(dac_word), .rb_act(rb_act), .rb_bit(rb_bit)
  );

  assign out_bit = rb_act ? rb_bit : work[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sdo_pull_o <= 1'b0;
    else        sdo_pull_o <= !out_bit;
endmodule

// File: rtl/dacsif_chk.sv
module dacsif_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_lvl,
  input logic              frame_rise,
  input logic              load_lvl,
  input logic              load_fall,
  input logic              clr_fall,
  input logic              commit,
  input logic              rb_act,
  input logic [WORD_W-1:0] work,
  input logic [WORD_W-1:0] in_reg,
  input logic              sdo_pull_o,
  input logic [CODE_W-1:0] dac_code_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  AST_CLR_TO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> dac_code_o == MID); // R10
  AST_SHORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rise && !commit) |=> $stable(in_reg)); // R3
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && !commit && !clr_fall) |=> dac_code_o == $past(in_reg[CODE_W-1:0])); // R5
  AST_AUTO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !load_lvl && !clr_fall) |=> dac_code_o == $past(work[CODE_W-1:0])); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fall && !commit && !clr_fall) |=> $stable(dac_code_o)); // R7
  AST_IDLE_NOSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_lvl && !frame_rise) |=> $stable(work)); // R4
  AST_SDO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_act |=> sdo_pull_o == !$past(work[WORD_W-1])); // R9
endmodule

bind dacsif_top dacsif_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .frame_lvl(s_lvl[dacsif_pkg::PIN_FRAME]), .frame_rise(s_rise[dacsif_pkg::PIN_FRAME]),
  .load_lvl(s_lvl[dacsif_pkg::PIN_LOAD]), .load_fall(s_fall[dacsif_pkg::PIN_LOAD]),
  .clr_fall(s_fall[dacsif_pkg::PIN_CLR]), .commit(commit), .rb_act(rb_act),
  .work(work), .in_reg(in_reg), .sdo_pull_o(sdo_pull_o), .dac_code_o(dac_code_o)
);

// File: tb/sim_dacsif_top.sv
module sim_dacsif_top;
  localparam int CLK_NS = 10;
  localparam int W      = 8;
  localparam int C      = 6;
  localparam int HALF   = 6;
  localparam int MID    = 1 << (C - 1);
  localparam int CMASK  = (1 << C) - 1;

  logic clk = 0, rst_n = 0;
  logic sck = 0, frame_n = 1, sdi = 0, load_n = 1, rdbk_n = 1, clr_n = 1;
  logic sdo_pull;
  logic [C-1:0] code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dacsif_top #(.WORD_W(W), .CODE_W(C)) u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .frame_n_i(frame_n), .sdi_i(sdi),
    .load_n_i(load_n), .rdbk_n_i(rdbk_n), .clr_n_i(clr_n),
    .sdo_pull_o(sdo_pull), .dac_code_o(code)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sends the n low bits of 'bits' MSB first; records the serial output before each fall
  task automatic send(input logic [31:0] bits, input int n, output logic [W-1:0] seen);
    seen = '0;
    frame_n = 0; tick(HALF);
    for (int k = 0; k < n; k++) begin
      sdi = bits[n-1-k]; sck = 1; tick(HALF);
      if (k < W) seen[W-1-k] = ~sdo_pull;
      sck = 0; tick(HALF);
    end
    frame_n = 1; tick(HALF + 3);
  endtask

  task automatic readback(output logic [W-1:0] v);
    rdbk_n = 0; tick(HALF + 2);
    for (int k = 0; k < W; k++) begin
      v[W-1-k] = ~sdo_pull;
      sck = 1; tick(HALF);
      sck = 0; tick(HALF);
    end
    rdbk_n = 1; tick(HALF);
  endtask

  task automatic pulse_load();
    load_n = 0; tick(8);
    load_n = 1; tick(8);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seen, v, prev;
    tick(5); rst_n = 1; tick(4);
    chk("R1 code", int'(code), MID);
    chk("R1 sdo", int'(sdo_pull), 1);
    readback(v);
    chk("R1 word", int'(v), MID);

    // exhaustive sweep in automatic-update mode
    load_n = 0; tick(8);
    prev = '0;
    for (int w = 0; w < (1 << W); w++) begin
      send(w, W, seen);
      chk("R9 chain", int'(seen), int'(prev));
      chk("R6 auto/R5 low bits", int'(code), w & CMASK);
      readback(v);
      chk("R8 readback/R2 capture", int'(v), w);
      prev = W'(w);
    end
    load_n = 1; tick(8);
    chk("R11 released", int'(sdo_pull), 0);

    send(32'h15, W, seen);
    chk("R7 load high", int'(code), 'hFF & CMASK);
    chk("R11 pull low", int'(sdo_pull), 1);
    pulse_load();
    chk("R5 load", int'(code), 'h15);

    send(32'h2A, W - 1, seen);
    chk("R3 short code", int'(code), 'h15);
    pulse_load();
    chk("R3 short input reg", int'(code), 'h15);
    load_n = 0; tick(8);
    send(32'h1F, 5, seen);
    chk("R3 short auto", int'(code), 'h15);

    send(32'h5A3, 11, seen);
    chk("R2 long code", int'(code), 'hA3 & CMASK);
    load_n = 1; tick(8);
    readback(v);
    chk("R2 long word", int'(v), 'hA3);

    sdi = 1;
    for (int k = 0; k < W; k++) begin
      sck = 1; tick(HALF); sck = 0; tick(HALF);
    end
    sdi = 0;
    pulse_load();
    chk("R4 ignored clocks", int'(code), 'hA3 & CMASK);

    clr_n = 0; tick(8);
    chk("R10 clear", int'(code), MID);
    clr_n = 1; tick(4);
    readback(v);
    chk("R10 register kept", int'(v), 'hA3);
    send(32'h3C, W, seen);
    chk("R10 parked", int'(code), MID);
    pulse_load();
    chk("R10 released by load", int'(code), 'h3C);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule